// File: doc/BRIEF.md
# Converter Peripheral Stop and Access-Gating Controller

This block governs the low-power stop state of a queued analog converter peripheral. A stop is in force whenever the software stop bit in the configuration register is set or the chip-level stop request input is high. On entry it aborts any running conversion sequence and drops the converter enable. From the next clock edge it clears a subset of the control and status registers and holds the periodic timer at zero. For the whole stop it refuses writes to every register except the configuration register, and it blanks the command/result RAM window in both directions.

When the stop condition goes away, a recovery down-counter loaded from the configuration register must run out before the converter counts as ready. Trigger requests that arrive during recovery are kept pending and start a sequence once ready. The converter, queue scheduler and RAM contents are simple stubs. Every register-bus access takes a single cycle: reads are combinational and writes take effect at the clock edge. The bus has no back-pressure, so there is no ready signal on it and a request is never stalled.

Address map (5-bit word address): 0 configuration (bit 0 stop, bit 1 sticky abort flag, bits 15:8 recovery count, reset value 0x0400). 1 control A. 2 control B. 3 control C. 4 status A. 5 status B. 6 direction. 7 port A. 8 port B. 16–31 RAM. Other addresses read zero and ignore writes.

Top module: `pstop_ctrl`

## Requirements
- R1: The block is stopped (`stopped_o` high) exactly when configuration bit 0 is set or `sys_stop_i` is high; `conv_en_o` is low whenever stopped.
- R2: When stop begins while a sequence is active, or in the same cycle as a trigger that would start one, `seq_active_o` is low after that edge and configuration bit 1 reads 1. The flag stays set until a configuration write with bit 1 = 1 clears it.
- R3: While stopped, writes to addresses 1–8 are ignored, and reads of them return their held values.
- R4: The configuration register stays writable while stopped; writing bit 0 = 0 ends a software stop.
- R5: While stopped, RAM reads (addresses 16–31) return 0 and RAM writes are discarded.
- R6: From the first edge of a stop, control B, control C, status A and status B read 0; control A keeps its value.
- R7: The timer output is 0 after any edge at which the block was stopped; otherwise it counts up by one per cycle, modulo the timer period.
- R8: `ready_o` is low while stopped. After release it stays low until the N-th edge, where N is configuration bits 15:8, and is high from that edge on.
- R9: A trigger seen while not stopped and not ready is held, and `seq_active_o` rises at the edge after `ready_o` rises.
- R10: A write to addresses 1–8 or 16–31 while stopped makes `wr_err_o` high for the one cycle after that write; configuration writes never do.
- R11: When not stopped, a write is visible to a read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_stop_i | input | 1 | Chip-level low-power stop request |
| bus_en_i | input | 1 | Register bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data (combinational) |
| wr_err_o | output | 1 | One-cycle pulse after a refused write |
| trig_i | input | 1 | Conversion trigger request |
| seq_done_i | input | 1 | Sequence completion from scheduler stub |
| conv_en_o | output | 1 | Converter enable to analog stub |
| seq_active_o | output | 1 | Conversion sequence in progress |
| ready_o | output | 1 | Converter stable, conversions allowed |
| stopped_o | output | 1 | Stop state in force |
| tmr_cnt_o | output | TMR_W | Periodic timer count |
| tmr_tick_o | output | 1 | Timer wrap pulse |

## Verification
The properties assume that `sys_stop_i`, the bus inputs and `trig_i` are synchronous to `clk` and stay stable around the rising edge. They also assume that `seq_done_i` comes only while a sequence is active. The bench changes every input just after a falling edge and pulses triggers and completions for one cycle. It reads registers only through the bus, so every gating rule is seen through `bus_rdata_o` and `wr_err_o`. Stop is entered both from the chip-level input and from the software bit. One entry is timed to meet a trigger in the same cycle, so the abort path is exercised without a running sequence.

// File: rtl/pstop_pkg.sv
package pstop_pkg;
  localparam int NGATED = 8;
  // gated register g lives at address g+1
  localparam logic [NGATED-1:0] CLR_ON_STOP = 8'b0001_1110;
  localparam int IDX_CFG = 0;
endpackage

// File: rtl/pstop_regs.sv
module pstop_regs
  import pstop_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4,
  parameter int REC_W = 8,
  parameter logic [REC_W-1:0] REC_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             abort_set_i,
  output logic             cfg_stop_o,
  output logic [REC_W-1:0] cfg_rec_o,
  output logic             gated_hit_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int PAD = DW - REC_W - 2;

  logic             stop_bit_q, abort_q;
  logic [REC_W-1:0] rec_q;
  logic             cfg_wr;
  logic [NGATED-1:0][DW-1:0] gq;

  assign cfg_wr = acc_i && we_i && (idx_i == IW'(IDX_CFG));
  assign gated_hit_o = acc_i && (idx_i >= IW'(1)) && (idx_i <= IW'(NGATED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_bit_q <= 1'b0;
      abort_q    <= 1'b0;
      rec_q      <= REC_INIT;
    end else begin
      if (cfg_wr) begin
        stop_bit_q <= wdata_i[0];
        rec_q      <= wdata_i[DW-1 -: REC_W];
      end
      abort_q <= abort_set_i || (abort_q && !(cfg_wr && wdata_i[1]));
    end
  end

  for (genvar g = 0; g < NGATED; g++) begin : g_reg
    localparam bit CLR = CLR_ON_STOP[g];
    logic [DW-1:0] q;
    logic          sel;
    assign sel = acc_i && we_i && (idx_i == IW'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (CLR && stop_i) q <= '0;
      else if (sel && !stop_i) q <= wdata_i;
    end
    assign gq[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IW'(IDX_CFG))
      rdata_o = {rec_q, {PAD{1'b0}}, abort_q, stop_bit_q};
    else if (gated_hit_o)
      rdata_o = gq[idx_i - IW'(1)];
  end

  assign cfg_stop_o = stop_bit_q;
  assign cfg_rec_o  = rec_q;
endmodule

// File: rtl/pstop_ram.sv
module pstop_ram #(
  parameter int DW = 16,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           stop_i,
  input  logic           acc_i,
  input  logic           we_i,
  input  logic [RAW-1:0] idx_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  localparam int DEPTH = 2 ** RAW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (acc_i && we_i && !stop_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = stop_i ? '0 : mem[idx_i];
endmodule

// File: rtl/pstop_seq.sv
module pstop_seq #(
  parameter int REC_W = 8,
  parameter int TMR_W = 4,
  parameter int TMR_PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic [REC_W-1:0] rec_load_i,
  input  logic             trig_i,
  input  logic             seq_done_i,
  output logic             ready_o,
  output logic             seq_active_o,
  output logic             abort_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic             tick_o
);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMR_PERIOD - 1);

  logic [REC_W-1:0] rec_q;
  logic [TMR_W-1:0] tmr_q;
  logic pend_q, act_q, stop_q;
  logic rec_zero, start;

  assign rec_zero = (rec_q == '0);
  assign ready_o  = !stop_i && rec_zero;
  assign start    = ready_o && !act_q && (trig_i || pend_q);
  assign abort_o  = stop_i && !stop_q && (act_q || (trig_i && rec_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      tmr_q  <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop_i;
      if (stop_i) begin
        rec_q  <= rec_load_i;
        tmr_q  <= '0;
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        if (!rec_zero) rec_q <= rec_q - REC_W'(1);
        tmr_q  <= (tmr_q == TMR_LAST) ? '0 : tmr_q + TMR_W'(1);
        pend_q <= start ? 1'b0 : (pend_q || (trig_i && !ready_o));
        if (start) act_q <= 1'b1;
        else if (seq_done_i) act_q <= 1'b0;
      end
    end
  end

  assign seq_active_o = act_q;
  assign tmr_o  = tmr_q;
  assign tick_o = !stop_i && (tmr_q == TMR_LAST);
endmodule

// File: rtl/pstop_ctrl.sv
module pstop_ctrl #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int REC_W = 8,
  parameter logic [REC_W-1:0] REC_INIT = 4,
  parameter int TMR_W = 4,
  parameter int TMR_PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_stop_i,
  input  logic             bus_en_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             wr_err_o,
  input  logic             trig_i,
  input  logic             seq_done_i,
  output logic             conv_en_o,
  output logic             seq_active_o,
  output logic             ready_o,
  output logic             stopped_o,
  output logic [TMR_W-1:0] tmr_cnt_o,
  output logic             tmr_tick_o
);
  localparam int IW = AW - 1;

  logic             ram_sel, reg_acc, ram_acc, stop;
  logic             cfg_stop, gated_hit, abort;
  logic [REC_W-1:0] cfg_rec;
  logic [DW-1:0]    reg_rd, ram_rd;
  logic             err_q;

  assign ram_sel = bus_addr_i[AW-1];
  assign reg_acc = bus_en_i && !ram_sel;
  assign ram_acc = bus_en_i && ram_sel;
  assign stop    = cfg_stop || sys_stop_i;

  pstop_regs #(.DW(DW), .IW(IW), .REC_W(REC_W), .REC_INIT(REC_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .stop_i(stop), .acc_i(reg_acc), .we_i(bus_we_i),
    .idx_i(bus_addr_i[IW-1:0]), .wdata_i(bus_wdata_i), .abort_set_i(abort),
    .cfg_stop_o(cfg_stop), .cfg_rec_o(cfg_rec), .gated_hit_o(gated_hit),
    .rdata_o(reg_rd)
  );

  pstop_ram #(.DW(DW), .RAW(IW)) u_ram (
    .clk(clk), .stop_i(stop), .acc_i(ram_acc), .we_i(bus_we_i),
    .idx_i(bus_addr_i[IW-1:0]), .wdata_i(bus_wdata_i), .rdata_o(ram_rd)
  );

  pstop_seq #(.REC_W(REC_W), .TMR_W(TMR_W), .TMR_PERIOD(TMR_PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop_i(stop), .rec_load_i(cfg_rec),
    .trig_i(trig_i), .seq_done_i(seq_done_i), .ready_o(ready_o),
    .seq_active_o(seq_active_o), .abort_o(abort), .tmr_o(tmr_cnt_o),
    .tick_o(tmr_tick_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= stop && bus_we_i && (ram_acc || gated_hit);
  end

  assign bus_rdata_o = ram_sel ? ram_rd : reg_rd;
  assign wr_err_o    = err_q;
  assign conv_en_o   = !stop;
  assign stopped_o   = stop;
endmodule

// File: rtl/pstop_chk.sv
module pstop_chk #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int TMR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_stop_i,
  input logic             bus_en_i,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [DW-1:0]    bus_rdata_o,
  input logic             wr_err_o,
  input logic             conv_en_o,
  input logic             seq_active_o,
  input logic             ready_o,
  input logic             stopped_o,
  input logic [TMR_W-1:0] tmr_cnt_o
);
  localparam logic [AW-1:0] A_CTLB = AW'(2);
  localparam logic [AW-1:0] A_DIR  = AW'(6);

  a_r1_sys_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
    sys_stop_i |-> (stopped_o && !conv_en_o));

  a_r2_abort_clears_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active_o && stopped_o) |=> !seq_active_o);

  a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopped_o && bus_en_i && bus_we_i && bus_addr_i == A_DIR)
     && bus_en_i && !bus_we_i && bus_addr_i == A_DIR)
    |-> (bus_rdata_o == $past(bus_rdata_o)));

  a_r5_ram_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && bus_en_i && !bus_we_i && bus_addr_i[AW-1]) |-> (bus_rdata_o == '0));

  a_r6_ctlb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopped_o) && bus_en_i && !bus_we_i && bus_addr_i == A_CTLB)
    |-> (bus_rdata_o == '0));

  a_r7_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |=> (tmr_cnt_o == '0));

  a_r8_not_ready_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |-> !ready_o);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(stopped_o && bus_en_i && bus_we_i));
endmodule

bind pstop_ctrl pstop_chk #(.AW(AW), .DW(DW), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_stop_i(sys_stop_i), .bus_en_i(bus_en_i),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .wr_err_o(wr_err_o), .conv_en_o(conv_en_o), .seq_active_o(seq_active_o),
  .ready_o(ready_o), .stopped_o(stopped_o), .tmr_cnt_o(tmr_cnt_o)
);

// File: tb/sim_pstop_ctrl.sv
module sim_pstop_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int TMR_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_stop = 1'b0, en = 1'b0, we = 1'b0, trig = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0, rd;
  logic wr_err, conv_en, seq_act, ready, stopped, tick;
  logic [TMR_W-1:0] tmr;
  int n_run = 0, n_fail = 0;
  logic [DW-1:0] got;

  always #(CLK_P/2) clk = ~clk;

  pstop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sys_stop_i(sys_stop), .bus_en_i(en),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rd),
    .wr_err_o(wr_err), .trig_i(trig), .seq_done_i(done), .conv_en_o(conv_en),
    .seq_active_o(seq_act), .ready_o(ready), .stopped_o(stopped),
    .tmr_cnt_o(tmr), .tmr_tick_o(tick)
  );

  typedef struct packed {
    logic        w;
    logic        stp;
    logic [4:0]  a;
    logic [15:0] d;
    logic [15:0] exp;
    logic        chk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 5'd1,  16'h1111, 16'h0000, 1'b0, 4'd11},
    '{1'b1, 1'b0, 5'd2,  16'h2222, 16'h0000, 1'b0, 4'd11},
    '{1'b1, 1'b0, 5'd4,  16'h3333, 16'h0000, 1'b0, 4'd11},
    '{1'b1, 1'b0, 5'd6,  16'h00F0, 16'h0000, 1'b0, 4'd11},
    '{1'b1, 1'b0, 5'd16, 16'hBEEF, 16'h0000, 1'b0, 4'd11},
    '{1'b0, 1'b0, 5'd1,  16'h0000, 16'h1111, 1'b1, 4'd11}, // R11
    '{1'b0, 1'b0, 5'd16, 16'h0000, 16'hBEEF, 1'b1, 4'd11},
    '{1'b0, 1'b1, 5'd1,  16'h0000, 16'h1111, 1'b1, 4'd3},  // R3
    '{1'b0, 1'b1, 5'd16, 16'h0000, 16'h0000, 1'b1, 4'd5},  // R5
    '{1'b1, 1'b1, 5'd1,  16'hAAAA, 16'h0000, 1'b0, 4'd3},
    '{1'b0, 1'b1, 5'd1,  16'h0000, 16'h1111, 1'b1, 4'd6},  // R6 kept
    '{1'b0, 1'b1, 5'd2,  16'h0000, 16'h0000, 1'b1, 4'd6},
    '{1'b0, 1'b1, 5'd4,  16'h0000, 16'h0000, 1'b1, 4'd6},
    '{1'b1, 1'b1, 5'd6,  16'h1234, 16'h0000, 1'b0, 4'd3},
    '{1'b0, 1'b1, 5'd6,  16'h0000, 16'h00F0, 1'b1, 4'd3},
    '{1'b1, 1'b1, 5'd16, 16'h5555, 16'h0000, 1'b0, 4'd5},
    '{1'b0, 1'b0, 5'd16, 16'h0000, 16'hBEEF, 1'b1, 4'd5},
    '{1'b0, 1'b0, 5'd2,  16'h0000, 16'h0000, 1'b1, 4'd6},
    '{1'b1, 1'b0, 5'd2,  16'h7777, 16'h0000, 1'b0, 4'd11},
    '{1'b0, 1'b0, 5'd2,  16'h0000, 16'h7777, 1'b1, 4'd11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; rd_o is sampled before the edge, outputs settle after it
  task automatic op(input logic w, input logic stp, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input logic tg, output logic [DW-1:0] rd_o);
    @(negedge clk);
    sys_stop = stp; en = 1'b1; we = w; addr = a; wd = d; trig = tg;
    #1 rd_o = rd;
    @(posedge clk);
    #1 en = 1'b0; we = 1'b0; trig = 1'b0;
  endtask

  task automatic idle(input logic stp, input logic tg, input logic dn);
    @(negedge clk);
    sys_stop = stp; en = 1'b0; trig = tg; done = dn;
    @(posedge clk);
    #1 trig = 1'b0; done = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset stopped_o", stopped, 0);
    check("R1 reset conv_en_o", conv_en, 1);
    check("R8 reset ready_o", ready, 1);
    check("R10 reset wr_err_o", wr_err, 0);
    op(0, 0, 0, 0, 0, got);
    check("R4 reset config value", got, 16'h0400);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].w, VEC[i].stp, VEC[i].a, VEC[i].d, 1'b0, got);
      if (VEC[i].chk) begin
        n_run++;
        if (got !== VEC[i].exp) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VEC[i].req, i, got, VEC[i].exp);
        end
      end
    end
    repeat (5) idle(0, 0, 0);

    // R10 refused write pulses error once; config write never does
    op(1, 1, 6, 16'h9999, 0, got);
    check("R10 error after gated write", wr_err, 1);
    idle(1, 0, 0);
    check("R10 error lasts one cycle", wr_err, 0);
    op(1, 1, 0, 16'h0400, 0, got);
    check("R10 no error on config write", wr_err, 0);
    check("R1 stopped by system request", stopped, 1);
    check("R1 converter disabled", conv_en, 0);
    check("R7 timer held", tmr, 0);
    check("R8 not ready while stopped", ready, 0);

    // R8 recovery, R7 timer restart
    idle(0, 0, 0);
    check("R8 not ready after edge 1", ready, 0);
    idle(0, 0, 0);
    idle(0, 0, 0);
    check("R7 timer counts from zero", tmr, 3);
    check("R8 not ready after edge 3", ready, 0);
    idle(0, 0, 0);
    check("R8 ready after edge 4", ready, 1);

    // R4 software stop enter and leave
    op(1, 0, 0, 16'h0401, 0, got);
    check("R4 software stop entered", stopped, 1);
    op(1, 0, 0, 16'h0400, 0, got);
    check("R4 software stop left", stopped, 0);

    // R9 trigger during recovery is held
    idle(0, 0, 0);
    idle(0, 1, 0);
    check("R9 no start while recovering", seq_act, 0);
    idle(0, 0, 0);
    idle(0, 0, 0);
    check("R9 ready rises", ready, 1);
    check("R9 not yet active", seq_act, 0);
    idle(0, 0, 0);
    check("R9 pending trigger starts", seq_act, 1);

    // R2 abort of running sequence
    idle(1, 0, 0);
    check("R2 sequence aborted", seq_act, 0);
    op(0, 1, 0, 0, 0, got);
    check("R2 abort flag set", got, 16'h0402);
    op(1, 1, 0, 16'h0402, 0, got);
    op(0, 0, 0, 0, 0, got);
    check("R2 abort flag cleared", got, 16'h0400);
    repeat (5) idle(0, 0, 0);

    // R2 stop in the same cycle as a start
    check("R2 ready before same-cycle case", ready, 1);
    idle(1, 1, 0);
    check("R2 same-cycle start blocked", seq_act, 0);
    op(0, 1, 0, 0, 0, got);
    check("R2 same-cycle abort flag", got, 16'h0402);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule